// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous SRAM whose data bus never needs an idle cycle between a write and a read. Address and control are registered on a rising clock edge, and the data for that command crosses the bus exactly two edges later, for both directions. Because reads and writes have the same latency, a controller can mix them freely on every cycle. The array depth, byte count and byte width are parameters.

A four-word burst is started by a load cycle and continued by advance cycles, in either a wrapping linear order or an XOR-based interleaved order. Three chip selects with mixed polarity gate new accesses. A clock-enable input freezes the whole block. Active-low per-byte masks choose which bytes a write changes. An asynchronous output enable gates the read drive. The bidirectional bus is split into `din`, `dout` and `dout_en`.

The write path is pipelined: write data is held for one more cycle before it reaches the array. A read that follows a write to the same word by one or two commands still returns the new bytes, because pending bytes are forwarded and merged with the array contents byte by byte.

Top module: `turnfree_sram`

## Requirements
- R1: A command sampled at rising edge k moves data at edge k+2. A write takes `din` at edge k+2. A read updates `dout` and raises `dout_en` at edge k+2, and both hold until the next enabled edge.
- R2: Reads and writes may alternate on every cycle with no idle cycle, and each read returns the data written by every earlier write command.
- R3: While `clk_en_n` is 1, a rising edge has no effect: no command is taken, no pipeline stage moves, and `dout` and `dout_en` stay unchanged.
- R4: A load cycle (`adv_ld`=0) with all three selects active (`cs0_n`=0, `cs1`=1, `cs2_n`=0) starts an access at `addr`: a write when `wr_n`=0, a read when `wr_n`=1.
- R5: An advance cycle (`adv_ld`=1) ignores `addr`, `wr_n` and the selects. It issues the next word of the running burst with the direction chosen at load.
- R6: Burst beat n (0 to 3, counting modulo 4) uses the word whose two low address bits are start^n when `order_il`=1 and start+n modulo 4 when `order_il`=0. The upper address bits stay those of the load.
- R7: A load cycle with any select inactive starts no access and ends the running burst, so later advance cycles issue nothing. Commands already in the pipeline still finish.
- R8: `dout_en` is 0 after edge k+2 when edge k took a deselecting load or a write.
- R9: `bw_n[i]`=0 enables byte i, bits [9i+8:9i] at the default byte width, for a write beat. The mask is sampled with every write command, including burst beats, and it is ignored on reads.
- R10: `oe_n`=1 forces `dout_en` to 0 at once, without a clock edge, and does not disturb the pipeline. When `oe_n` returns to 0, the pending read data drives again.
- R11: A read issued one or two commands after a write to the same word returns the new bytes of that write, merged with the old contents of the bytes it masked off.
- R12: `rst_n`=0 at a rising edge clears the pipeline and the burst state, so `dout_en` is 0 and no access that was in flight completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 stalls the block |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| wr_n | input | 1 | Direction at load: 0 write, 1 read |
| addr | input | ADDR_W | Word address, taken on load cycles |
| bw_n | input | NBYTES | Active-low byte write masks |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| din | input | NBYTES*BYTE_W | Write data, taken two edges after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | NBYTES*BYTE_W | Read data, zero while not driving |
| dout_en | output | 1 | High while the block drives read data |

## Verification
A command sampled at edge k has its write data taken at edge k+2, and its read result and drive enable change at edge k+2. An edge with `clk_en_n` high does not count toward those two. The bench drives inputs at the falling edge and updates its reference model right after each rising edge. It compares `dout_en` and `dout` at the next falling edge, so every read is checked in the cycle after its second enabled edge. The output-enable gating is checked one time unit after `oe_n` changes in mid-cycle, with no clock edge in between.

// File: rtl/turnfree_pkg.sv
// Shared helpers for the no-turnaround SRAM.
// Assumes a burst is always four words, selected by the two low address bits.
package turnfree_pkg;

    localparam int BEAT_W = 2;

    // Low address bits of a burst beat for the chosen order
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic              il,
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat
    );
        return il ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/tf_cmd_seq.sv
// Command sequencer: turns load/advance cycles into one access per edge.
// On a load it takes the external address and direction if the chip is
// selected. On an advance it steps the four-beat burst counter.
// Assumes ADDR_W > 2 and a static burst order during operation.
module tf_cmd_seq
    import turnfree_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              adv_ld,
    input  logic              chip_on,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] bw_n,
    input  logic              order_il,
    output logic              cmd_v,
    output logic              cmd_w,
    output logic [ADDR_W-1:0] cmd_a,
    output logic [NBYTES-1:0] cmd_m
);

    logic              burst_on;
    logic              burst_wr;
    logic [ADDR_W-1:0] base_a;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] nxt_beat;

    assign nxt_beat = beat + 1'b1;

    // Issue this edge's command from the pins or from the burst state
    always_comb begin
        cmd_m = bw_n;
        if (!adv_ld) begin
            cmd_v = chip_on;
            cmd_w = !wr_n;
            cmd_a = addr;
        end else begin
            cmd_v = burst_on;
            cmd_w = burst_wr;
            cmd_a = base_a;
            cmd_a[BEAT_W-1:0] = beat_offset(order_il, base_a[BEAT_W-1:0], nxt_beat);
        end
    end

    // Track the running burst: start, end or step it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_on <= 1'b0;
            burst_wr <= 1'b0;
            base_a   <= '0;
            beat     <= '0;
        end else if (en) begin
            if (!adv_ld) begin
                burst_on <= chip_on;
                burst_wr <= !wr_n;
                base_a   <= addr;
                beat     <= '0;
            end else if (burst_on) begin
                beat     <= nxt_beat;
            end
        end
    end

endmodule

// File: rtl/tf_array.sv
// Storage array with byte-masked synchronous write and asynchronous read.
// A read of a word written at the same edge returns the old contents;
// the caller forwards anything newer. Contents are not reset.
module tf_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     en,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [NBYTES-1:0]        wr_mask_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = NBYTES * BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write the unmasked bytes of the committed word
    always_ff @(posedge clk) begin
        if (en && wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (!wr_mask_n[b]) begin
                    mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Combinational read port
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/turnfree_sram.sv
// Pipelined synchronous SRAM with equal read and write latency.
// Stage s1 holds the command taken at the last edge and reads the array.
// Stage s2 meets its write data on din. A write buffer commits one edge
// later, and the output register drives read data two edges after the command.
// Reads merge pending write bytes (write buffer, then din) over the array.
// Assumes order_il only changes while in reset.
module turnfree_sram
    import turnfree_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en_n,
    input  logic                     cs0_n,
    input  logic                     cs1,
    input  logic                     cs2_n,
    input  logic                     adv_ld,
    input  logic                     wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES-1:0]        bw_n,
    input  logic                     order_il,
    input  logic [NBYTES*BYTE_W-1:0] din,
    input  logic                     oe_n,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dout_en
);

    localparam int DATA_W = NBYTES * BYTE_W;

    typedef logic [NBYTES-1:0][BYTE_W-1:0] word_t;

    logic              en;
    logic              chip_on;

    logic              nx_v, nx_w;
    logic [ADDR_W-1:0] nx_a;
    logic [NBYTES-1:0] nx_m;

    logic              s1_v, s1_w;
    logic [ADDR_W-1:0] s1_a;
    logic [NBYTES-1:0] s1_m;
    logic              s2_v, s2_w;
    logic [ADDR_W-1:0] s2_a;
    logic [NBYTES-1:0] s2_m;

    logic              wb_v;
    logic [ADDR_W-1:0] wb_a;
    logic [NBYTES-1:0] wb_m;
    word_t             wb_d;

    word_t             din_w;
    word_t             arr_rd;
    word_t             merged;
    word_t             rd_q;
    logic [DATA_W-1:0] dout_q;
    logic              drv_q;

    assign en      = !clk_en_n;
    assign chip_on = !cs0_n && cs1 && !cs2_n;
    assign din_w   = din;

    tf_cmd_seq #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .adv_ld   (adv_ld),
        .chip_on  (chip_on),
        .wr_n     (wr_n),
        .addr     (addr),
        .bw_n     (bw_n),
        .order_il (order_il),
        .cmd_v    (nx_v),
        .cmd_w    (nx_w),
        .cmd_a    (nx_a),
        .cmd_m    (nx_m)
    );

    tf_array #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) u_arr (
        .clk       (clk),
        .en        (en),
        .wr_en     (wb_v),
        .wr_addr   (wb_a),
        .wr_data   (wb_d),
        .wr_mask_n (wb_m),
        .rd_addr   (s1_a),
        .rd_data   (arr_rd)
    );

    // Per-byte forwarding: the newest pending write byte wins over the array
    for (genvar b = 0; b < NBYTES; b++) begin : g_fwd
        logic hit_buf, hit_bus;
        assign hit_buf   = wb_v && (wb_a == s1_a) && !wb_m[b];
        assign hit_bus   = s2_v && s2_w && (s2_a == s1_a) && !s2_m[b];
        assign merged[b] = hit_bus ? din_w[b] : (hit_buf ? wb_d[b] : arr_rd[b]);
    end

    // Advance the command, write-buffer and read-data pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_w   <= 1'b0;
            s1_a   <= '0;
            s1_m   <= '1;
            s2_v   <= 1'b0;
            s2_w   <= 1'b0;
            s2_a   <= '0;
            s2_m   <= '1;
            wb_v   <= 1'b0;
            wb_a   <= '0;
            wb_m   <= '1;
            wb_d   <= '0;
            rd_q   <= '0;
            dout_q <= '0;
            drv_q  <= 1'b0;
        end else if (en) begin
            s1_v   <= nx_v;
            s1_w   <= nx_w;
            s1_a   <= nx_a;
            s1_m   <= nx_m;
            s2_v   <= s1_v;
            s2_w   <= s1_w;
            s2_a   <= s1_a;
            s2_m   <= s1_m;
            wb_v   <= s2_v && s2_w;
            wb_a   <= s2_a;
            wb_m   <= s2_m;
            wb_d   <= din_w;
            rd_q   <= merged;
            dout_q <= rd_q;
            drv_q  <= s2_v && !s2_w;
        end
    end

    // Asynchronous output gating
    assign dout_en = drv_q && !oe_n;
    assign dout    = dout_en ? dout_q : '0;

endmodule

// File: rtl/tf_sram_chk.sv
// Assertion checker for turnfree_sram, attached with bind below.
// Watches the pins and the registered drive state of the output stage.
module tf_sram_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              adv_ld,
    input logic              cs0_n,
    input logic              cs1,
    input logic              cs2_n,
    input logic              wr_n,
    input logic              oe_n,
    input logic              dout_en,
    input logic              drv_q,
    input logic [DATA_W-1:0] dout_q
);

    logic picked;
    logic go;

    assign picked = !cs0_n && cs1 && !cs2_n;
    assign go     = rst_n && !clk_en_n;

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(dout_q) && $stable(drv_q)));

    // R1
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(go && !adv_ld && picked && wr_n, 2) && $past(go) && go) |=> drv_q);

    // R8
    quiet_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(go && !adv_ld && (!picked || !wr_n), 2) && $past(go) && go) |=> !drv_q);

    // R10
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    // R10
    drive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> drv_q);

endmodule

bind turnfree_sram tf_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .cs0_n    (cs0_n),
    .cs1      (cs1),
    .cs2_n    (cs2_n),
    .wr_n     (wr_n),
    .oe_n     (oe_n),
    .dout_en  (dout_en),
    .drv_q    (drv_q),
    .dout_q   (dout_q)
);

// File: tb/tb_turnfree_sram.sv
// Self-checking bench: a reference model built from the requirements tracks
// memory, the two-stage command pipe and the burst state; outputs are compared
// at every falling edge.
module tb_turnfree_sram;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int NBYTES     = 2;
    localparam int BYTE_W     = 9;
    localparam int DATA_W     = NBYTES * BYTE_W;
    localparam int DEPTH      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_en_n = 1'b0;
    logic              cs0_n = 1'b1;
    logic              cs1 = 1'b0;
    logic              cs2_n = 1'b1;
    logic              adv_ld = 1'b0;
    logic              wr_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [NBYTES-1:0] bw_n = '1;
    logic              order_il = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic              oe_n = 1'b0;
    logic [DATA_W-1:0] dout;
    logic              dout_en;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R12";

    // Reference model state
    logic [DATA_W-1:0] mmem [DEPTH];
    bit                m1_v, m1_w, m2_v, m2_w;
    logic [ADDR_W-1:0] m1_a, m2_a;
    logic [NBYTES-1:0] m1_m, m2_m;
    bit                mb_on, mb_wr;
    logic [ADDR_W-1:0] mb_base;
    logic [1:0]        mb_beat;
    bit                exp_drv;
    logic [DATA_W-1:0] exp_dat;

    turnfree_sram #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_n (clk_en_n),
        .cs0_n    (cs0_n),
        .cs1      (cs1),
        .cs2_n    (cs2_n),
        .adv_ld   (adv_ld),
        .wr_n     (wr_n),
        .addr     (addr),
        .bw_n     (bw_n),
        .order_il (order_il),
        .din      (din),
        .oe_n     (oe_n),
        .dout     (dout),
        .dout_en  (dout_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired during %s act=0 exp=1", cur_req);
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s act=%h exp=%h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Byte-masked update from the mask rule of R9
    function automatic logic [DATA_W-1:0] put_bytes(input logic [DATA_W-1:0] old,
            input logic [DATA_W-1:0] nw, input logic [NBYTES-1:0] mask_n);
        logic [DATA_W-1:0] r;
        r = old;
        for (int b = 0; b < NBYTES; b++)
            if (!mask_n[b]) r[b*BYTE_W +: BYTE_W] = nw[b*BYTE_W +: BYTE_W];
        return r;
    endfunction

    // Model one rising edge from the pins, following R1 to R12
    task automatic model_edge();
        bit                n_v, n_w, chip;
        logic [ADDR_W-1:0] n_a;
        logic [1:0]        nb;
        if (!rst_n) begin
            m1_v = 0; m2_v = 0; mb_on = 0; exp_drv = 0;
        end else if (!clk_en_n) begin
            chip = !cs0_n && cs1 && !cs2_n;
            nb   = mb_beat + 2'd1;
            if (!adv_ld) begin
                n_v = chip; n_w = !wr_n; n_a = addr;
            end else begin
                n_v = mb_on; n_w = mb_wr; n_a = mb_base;
                n_a[1:0] = order_il ? (mb_base[1:0] ^ nb) : (mb_base[1:0] + nb);
            end
            exp_drv = 0;
            if (m2_v) begin
                if (m2_w) mmem[m2_a] = put_bytes(mmem[m2_a], din, m2_m);
                else begin exp_drv = 1; exp_dat = mmem[m2_a]; end
            end
            m2_v = m1_v; m2_w = m1_w; m2_a = m1_a; m2_m = m1_m;
            m1_v = n_v;  m1_w = n_w;  m1_a = n_a;  m1_m = bw_n;
            if (!adv_ld) begin
                mb_on = chip; mb_wr = !wr_n; mb_base = addr; mb_beat = 0;
            end else if (mb_on) begin
                mb_beat = nb;
            end
        end
    endtask

    task automatic check_out();
        bit want;
        want = exp_drv && !oe_n;
        chk(dout_en === want, "dout_en", DATA_W'(dout_en), DATA_W'(want));
        if (want) chk(dout === exp_dat, "dout", dout, exp_dat);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_out();
    endtask

    // One enabled cycle; sel_mode 0 selects, 1..3 leaves one select inactive
    task automatic op(input bit ld, input int sel_mode, input bit wrn,
                      input int a, input logic [NBYTES-1:0] m);
        clk_en_n = 1'b0;
        adv_ld   = !ld;
        cs0_n    = (sel_mode == 1);
        cs1      = (sel_mode != 2);
        cs2_n    = (sel_mode == 3);
        wr_n     = wrn;
        addr     = ADDR_W'(a);
        bw_n     = m;
        din      = DATA_W'($urandom);
        cycle();
    endtask

    task automatic stall();
        clk_en_n = 1'b1;
        adv_ld   = 1'($urandom);
        cs0_n    = 1'($urandom);
        cs1      = 1'($urandom);
        cs2_n    = 1'($urandom);
        wr_n     = 1'($urandom);
        addr     = ADDR_W'($urandom);
        bw_n     = NBYTES'($urandom);
        din      = DATA_W'($urandom);
        cycle();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(1, 2, 1, 0, '1);
    endtask

    task automatic do_reset(input bit il);
        rst_n = 1'b0;
        order_il = il;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic burst_tests();
        // R4 R6: load a read at a start with low bits 01, then three advances
        cur_req = "R6";
        op(1, 0, 1, 9, '1);
        // R5: address, direction and selects during advance are ignored
        cur_req = "R5";
        op(0, 1, 0, 50, '0);
        op(0, 2, 0, 33, '0);
        op(0, 0, 0, 17, '0);
        cur_req = "R6";
        op(0, 0, 1, 0, '1);  // wraps to the first word again
        idle(2);
        // R9: burst write with a different mask on each beat, then read back
        cur_req = "R9";
        op(1, 0, 0, 14, 2'b10);
        op(0, 0, 1, 0, 2'b01);
        op(0, 0, 1, 0, 2'b00);
        op(0, 0, 1, 0, 2'b11);
        op(1, 0, 1, 12, 2'b00);  // read burst; mask ignored
        op(0, 0, 1, 0, 2'b00);
        op(0, 0, 1, 0, 2'b00);
        op(0, 0, 1, 0, 2'b00);
        idle(2);
        // R7: a deselecting load ends the burst; later advances issue nothing
        cur_req = "R7";
        op(1, 0, 1, 20, '1);
        op(0, 0, 1, 0, '1);
        op(1, 3, 1, 20, '1);
        op(0, 0, 1, 0, '1);
        op(0, 0, 0, 0, '0);
        idle(2);
    endtask

    task automatic random_run(input int n);
        int r;
        for (int i = 0; i < n; i++) begin
            r = int'($urandom % 100);
            oe_n = (($urandom % 20) == 0);
            if (r < 8) stall();
            else op(($urandom % 100) < 65, (($urandom % 10) == 0) ? int'(1 + $urandom % 3) : 0,
                    1'($urandom), int'($urandom % 8), NBYTES'($urandom));
        end
        oe_n = 1'b0;
        idle(2);
    endtask

    initial begin
        void'($urandom(32'd5171));
        // R12: reset state
        cur_req = "R12";
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        // R4: fill every word with back-to-back loaded writes
        cur_req = "R4";
        for (int a = 0; a < DEPTH; a++) op(1, 0, 0, a, '0);
        idle(2);
        // R1: single read, data due two edges later
        cur_req = "R1";
        op(1, 0, 1, 5, '1);
        idle(3);
        // R2: alternate writes and reads every cycle
        cur_req = "R2";
        for (int i = 0; i < 8; i++) op(1, 0, i % 2, (i * 3) % 16, '0);
        idle(2);
        // R11: read right after a write, and one command later with a mask
        cur_req = "R11";
        op(1, 0, 0, 20, 2'b00);
        op(1, 0, 1, 20, 2'b00);
        op(1, 0, 0, 21, 2'b10);
        op(1, 0, 1, 3, 2'b00);
        op(1, 0, 1, 21, 2'b00);
        idle(3);
        // R8: write then deselect; drive drops two edges later
        cur_req = "R8";
        op(1, 0, 1, 7, '1);
        op(1, 0, 1, 8, '1);
        op(1, 0, 0, 7, '0);
        op(1, 1, 1, 7, '1);
        idle(3);
        // R3: stall in the middle of pending reads
        cur_req = "R3";
        op(1, 0, 1, 3, '1);
        op(1, 0, 1, 4, '1);
        stall(); stall();
        op(1, 2, 1, 0, '1);
        stall();
        idle(3);
        // R10: output enable acts without a clock edge
        cur_req = "R10";
        op(1, 0, 1, 9, '1);
        idle(2);
        oe_n = 1'b1;
        #1;
        chk(dout_en === 1'b0, "dout_en async off", DATA_W'(dout_en), '0);
        oe_n = 1'b0;
        #1;
        chk(dout_en === 1'b1, "dout_en async on", DATA_W'(dout_en), DATA_W'(1));
        chk(dout === exp_dat, "dout after oe", dout, exp_dat);
        idle(2);
        // R12: a read in flight is dropped by reset
        cur_req = "R12";
        op(1, 0, 1, 10, '1);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        idle(3);
        burst_tests();
        cur_req = "R2";
        random_run(1500);
        // Interleaved order, selected while in reset
        cur_req = "R12";
        do_reset(1'b1);
        burst_tests();
        cur_req = "R2";
        random_run(1500);
        summary();
        $finish;
    end

endmodule